// File: doc/BRIEF.md
# Cascadable Dual-Clock Pseudo-Dual-Port RAM

This block is a memory with one write-only port and one read-only port, each running on its own clock. Each port captures its address and control on the rising edge of its clock. A write is held in a one-entry stage and stored in the array at the next enabled write-clock edge. A read samples the array on an enabled read-clock edge. A parameter can add an output register, which gives one more read-clock cycle of latency.

Each port has a 3-bit select input that acts as the most significant address bits. Each instance carries its own 3-bit match value. Up to eight instances can share the address and data buses, and their read outputs can be combined with a bitwise OR, because an instance whose select does not match drives zeros. A reset clears the port registers only. The stored words are never touched by reset.

Top module: `cascade_pdp_ram`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, `rd_data` is zero until a read whose select matches has completed.
- R2: A write presented on one enabled write-clock edge with `wr_en` high and `wr_cs` equal to CS_MATCH is captured there. It is stored at the next write-clock edge at which `wr_ce` is high, and later reads of that address return it.
- R3: When `wr_cs` differs from CS_MATCH, the write is dropped. When `rd_cs` differs from CS_MATCH on an enabled read edge, the read result is zero.
- R4: With OUT_REG=0, `rd_data` shows the word one read-clock edge after the address is sampled. With OUT_REG=1, it shows the word two edges after, and after one edge it still holds the earlier value.
- R5: While `wr_ce` is low, a captured write is held and not stored. It is stored at the first later edge where `wr_ce` is high.
- R6: While `rd_ce` is low, `rd_data` holds its value whatever the read address and select do.
- R7: Reset clears `rd_data` to zero and leaves every stored word unchanged.
- R8: A write that has been captured but not yet stored when reset is asserted is discarded.
- R9: If the read port samples an address on the same edge at which a write to that address is stored (both ports on one clock), the read returns the old word.
- R10: The bitwise OR of the outputs of instances with distinct CS_MATCH values, sharing all buses, gives the word of the instance that the select addresses, and zero when no instance matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock, rising edge |
| rd_clk | input | 1 | Read port clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wr_ce | input | 1 | Write port clock enable, active high |
| wr_en | input | 1 | Write request, active high |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| wr_cs | input | 3 | Write select (upper address bits) |
| rd_ce | input | 1 | Read port clock enable, active high |
| rd_addr | input | AW | Read word address |
| rd_cs | input | 3 | Read select (upper address bits) |
| rd_data | output | DW | Read data, zero when the select did not match |

## Verification
The bench builds two instances with AW=4 and DW=8, sharing every bus. One has CS_MATCH=5 and OUT_REG=0. The other has CS_MATCH=2 and OUT_REG=1. With these small widths, all 128 select/address combinations can be written and read back. This covers both read latencies, the select decode and the OR-combined cascade output. A single clock drives both ports, so the same-edge collision case can be reached.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  localparam int CS_W = 3;
  typedef logic [CS_W-1:0] cs_t;
endpackage

// File: rtl/pdp_rst_sync.sv
module pdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/pdp_wr_stage.sv
module pdp_wr_stage
  import pdp_pkg::*;
#(
  parameter int  AW       = 4,
  parameter int  DW       = 8,
  parameter cs_t CS_MATCH = '0
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ce,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  cs_t           cs,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    data_d = data_q;
    if (ce) begin
      pend_d = en && (cs == CS_MATCH);
      addr_d = addr;
      data_d = data;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign commit = ce && pend_q;
  assign c_addr = addr_q;
  assign c_data = data_q;

  // R5: a disabled clock freezes the captured write
  p_hold_wr_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !ce |=> $stable({pend_q, addr_q, data_q}));
endmodule

// File: rtl/pdp_rd_stage.sv
module pdp_rd_stage
  import pdp_pkg::*;
#(
  parameter int  DW       = 8,
  parameter cs_t CS_MATCH = '0
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ce,
  input  cs_t           cs,
  input  logic [DW-1:0] arr_word,
  output logic [DW-1:0] rdat
);
  logic [DW-1:0] rdat_q, rdat_d;

  always_comb begin
    rdat_d = rdat_q;
    if (ce) rdat_d = (cs == CS_MATCH) ? arr_word : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rdat_q <= '0;
    else         rdat_q <= rdat_d;
  end

  assign rdat = rdat_q;

  // R3: a non-matching select yields zero
  p_nomatch_zero_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (ce && cs != CS_MATCH) |=> rdat_q == '0);
  // R6: disabled read clock holds the result
  p_hold_rd_r6: assert property (@(posedge clk) disable iff (!srst_n)
    !ce |=> $stable(rdat_q));
endmodule

// File: rtl/cascade_pdp_ram.sv
module cascade_pdp_ram
  import pdp_pkg::*;
#(
  parameter int  AW       = 4,
  parameter int  DW       = 8,
  parameter cs_t CS_MATCH = '0,
  parameter bit  OUT_REG  = 1'b0
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_ce,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CS_W-1:0]   wr_cs,
  input  logic              rd_ce,
  input  logic [AW-1:0]     rd_addr,
  input  logic [CS_W-1:0]   rd_cs,
  output logic [DW-1:0]     rd_data
);
  localparam int DEPTH = 1 << AW;

  logic          wr_srst_n, rd_srst_n;
  logic          commit;
  logic [AW-1:0] c_addr;
  logic [DW-1:0] c_data;
  logic [DW-1:0] rdat;
  logic [DW-1:0] mem [DEPTH];

  pdp_rst_sync #(.STAGES(2)) u_wr_rst (
    .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  pdp_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  pdp_wr_stage #(.AW(AW), .DW(DW), .CS_MATCH(CS_MATCH)) u_wr (
    .clk(wr_clk), .srst_n(wr_srst_n), .ce(wr_ce), .en(wr_en),
    .addr(wr_addr), .data(wr_data), .cs(wr_cs),
    .commit(commit), .c_addr(c_addr), .c_data(c_data));

  // storage array: no reset, contents survive port resets
  always_ff @(posedge wr_clk) begin
    if (commit) mem[c_addr] <= c_data;
  end

  pdp_rd_stage #(.DW(DW), .CS_MATCH(CS_MATCH)) u_rd (
    .clk(rd_clk), .srst_n(rd_srst_n), .ce(rd_ce), .cs(rd_cs),
    .arr_word(mem[rd_addr]), .rdat(rdat));

  generate
    if (OUT_REG) begin : g_oreg
      logic [DW-1:0] out_q, out_d;
      always_comb begin
        out_d = rd_ce ? rdat : out_q;
      end
      always_ff @(posedge rd_clk or negedge rd_srst_n) begin
        if (!rd_srst_n) out_q <= '0;
        else            out_q <= out_d;
      end
      assign rd_data = out_q;
    end else begin : g_direct
      assign rd_data = rdat;
    end
  endgenerate

  // R2: a committed word is present in the array at the next edge
  p_write_lands_r2: assert property (@(posedge wr_clk) disable iff (!wr_srst_n)
    commit |=> mem[$past(c_addr)] == $past(c_data));
endmodule

// File: tb/cascade_pdp_ram_test.sv
`timescale 1ns/1ps
module cascade_pdp_ram_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_ce = 1'b0, wr_en = 1'b0, rd_ce = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_cs = '0, rd_cs = '0;
  logic [7:0] q_a, q_b;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cascade_pdp_ram #(.AW(4), .DW(8), .CS_MATCH(3'd5), .OUT_REG(1'b0)) uut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_cs(wr_cs), .rd_ce(rd_ce),
    .rd_addr(rd_addr), .rd_cs(rd_cs), .rd_data(q_a));
  cascade_pdp_ram #(.AW(4), .DW(8), .CS_MATCH(3'd2), .OUT_REG(1'b1)) uut_reg (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .wr_ce(wr_ce), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_cs(wr_cs), .rd_ce(rd_ce),
    .rd_addr(rd_addr), .rd_cs(rd_cs), .rd_data(q_b));

  function automatic logic [7:0] fdat(int cs, int a);
    return 8'(((cs * 16) + a) * 7 + 3);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(int cs, int a, logic [7:0] d);
    @(negedge clk);
    wr_ce = 1'b1; wr_en = 1'b1;
    wr_cs = 3'(cs); wr_addr = 4'(a); wr_data = d;
  endtask

  task automatic flush();
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); wr_ce = 1'b0;
  endtask

  // a: expected from instance with match 5, b: from instance with match 2
  task automatic do_read(int cs, int a, logic [7:0] ea, logic [7:0] eb, string tag);
    @(negedge clk);
    rd_ce = 1'b1; rd_cs = 3'(cs); rd_addr = 4'(a);
    @(posedge clk); #1;
    chk({tag, " direct"}, q_a, ea);
    @(posedge clk); #1;
    chk({tag, " registered"}, q_b, eb);
    chk("R10 or-combined", q_a | q_b, ea | eb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    chk("R1 reset direct", q_a, 8'h00);
    chk("R1 reset registered", q_b, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R1 after release", q_a | q_b, 8'h00);

    // R2 R3: sweep every select/address pair
    for (int cs = 0; cs < 8; cs++)
      for (int a = 0; a < 16; a++)
        do_write(cs, a, fdat(cs, a));
    flush();
    for (int cs = 0; cs < 8; cs++)
      for (int a = 0; a < 16; a++)
        do_read(cs, a, (cs == 5) ? fdat(5, a) : 8'h00,
                (cs == 2) ? fdat(2, a) : 8'h00,
                (cs == 5 || cs == 2) ? "R2 sweep" : "R3 nomatch");

    // R4: latency difference
    do_read(2, 3, 8'h00, fdat(2, 3), "R4 setup");
    @(negedge clk); rd_cs = 3'd2; rd_addr = 4'd4;
    @(posedge clk); #1;
    chk("R4 registered not yet", q_b, fdat(2, 3));
    @(posedge clk); #1;
    chk("R4 registered two edges", q_b, fdat(2, 4));

    // R6: read clock disabled
    @(negedge clk); rd_ce = 1'b0; rd_addr = 4'd7; rd_cs = 3'd5;
    repeat (3) @(posedge clk); #1;
    chk("R6 hold registered", q_b, fdat(2, 4));
    chk("R6 hold direct", q_a, 8'h00);

    // R5: write clock disabled holds pending write
    do_write(5, 0, 8'hEE);
    @(negedge clk); wr_ce = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    do_read(5, 0, fdat(5, 0), 8'h00, "R5 not stored");
    @(negedge clk); wr_ce = 1'b1;
    @(negedge clk); wr_ce = 1'b0;
    do_read(5, 0, 8'hEE, 8'h00, "R5 stored");

    // R8 R7: reset drops pending write, keeps contents
    do_read(2, 9, 8'h00, fdat(2, 9), "R7 preload");
    do_write(5, 1, 8'h11);
    @(negedge clk); wr_ce = 1'b0; wr_en = 1'b0; rd_ce = 1'b0; rst_n = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R7 reset clears direct", q_a, 8'h00);
    chk("R7 reset clears registered", q_b, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); wr_ce = 1'b1;
    @(negedge clk); wr_ce = 1'b0;
    do_read(5, 1, fdat(5, 1), 8'h00, "R8 pending dropped");
    for (int a = 0; a < 16; a++) begin
      do_read(5, a, (a == 0) ? 8'hEE : fdat(5, a), 8'h00, "R7 kept");
      do_read(2, a, 8'h00, fdat(2, a), "R7 kept");
    end

    // R9: same-edge collision returns old word
    @(negedge clk); rd_ce = 1'b0;
    do_write(5, 2, 8'h77);
    @(negedge clk); wr_en = 1'b0;
    rd_ce = 1'b1; rd_cs = 3'd5; rd_addr = 4'd2;
    @(posedge clk); #1;
    chk("R9 old word", q_a, fdat(5, 2));
    @(negedge clk); wr_ce = 1'b0;
    @(posedge clk); #1;
    chk("R9 new word next", q_a, 8'h77);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule